// File: doc/BRIEF.md
# Daisy-Chain Bus Arbiter

This block decides which of several potential bus masters may drive a shared bus. Every device's request is ORed onto one common request line, and that line is the only request the central controller looks at. When the bus is free and the common line is high, the controller raises a single grant into the head of a chain of per-device cells. Each cell keeps the grant if its device is asking for the bus. If not, it hands the grant on to the next cell. Device 0 sits at the head of the chain and has the highest priority; the device at the tail has the lowest.

The cell that takes the grant sets an ownership flag. The flag stays set until that device pulses its release input, even if a device of higher priority starts asking in the meantime. After a release the controller waits before it looks at requests again, so every handover has a fixed gap. Priority is given only by position in the chain, and nothing keeps a low-priority device from being locked out for as long as devices ahead of it keep asking. All pins are plain control signals, so there is no valid/ready handshake. Index i in each vector belongs to device i.

Top module: `daisy_arbiter`

## Requirements
- R1: During and right after reset, no ownership flag is set and the chain grant is low.
- R2: The shared request output is the OR of all device request bits, in the same cycle.
- R3: If the controller is idle and the shared request is high at a clock edge, the chain grant is high from that edge on.
- R4: At the first edge at which the chain grant is high and no device owns the bus, the lowest-index requesting device becomes owner. Bit i of the ownership output belongs to device i, and device 0 has the highest priority.
- R5: At most one ownership bit is set at any time.
- R6: An owner keeps the bus until it pulses its own release bit. This holds if higher-priority devices start requesting and if the owner drops its own request.
- R7: A release bit from a device that does not own the bus has no effect.
- R8: At the edge that samples the owner's release, ownership clears and the chain grant goes low. The grant stays low for exactly two cycles and rises again at the next edge if a request is still pending.
- R9: If all requests go away while the chain grant is high and nobody owns the bus, the grant drops at the next edge and no owner is set.
- R10: While the bus is owned, the chain grant stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | N_DEV | Per-device bus request |
| dev_rel | input | N_DEV | Per-device one-cycle release pulse |
| dev_own | output | N_DEV | Per-device ownership flag |
| shared_req | output | 1 | Combined (ORed) request line |
| chain_gnt | output | 1 | Grant driven into the head of the chain |

## Verification
The bench builds the arbiter with four devices. At that size all fifteen non-empty request patterns can be swept. For each pattern the bench computes the winner as the lowest set bit. The same sweep also has a higher-priority device join while the bus is owned and has every non-owner pulse release, so hold, ignored release, the two-cycle gap and re-arbitration are all checked for each possible owner. A separate run sends a request that vanishes before capture, and another has devices 0 and 3 competing over and over so that device 3 is starved.

// File: rtl/daisy_pkg.sv
package daisy_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,
    ARB_GRANT = 2'd1,
    ARB_COOL  = 2'd2
  } arb_state_t;
endpackage

// File: rtl/daisy_ctrl.sv
module daisy_ctrl
  import daisy_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic shared_req,
  input  logic any_owner,
  input  logic rel_any,
  output logic chain_gnt
);
  arb_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ARB_IDLE:  if (shared_req) st_d = ARB_GRANT;
      ARB_GRANT: begin
        if (rel_any) st_d = ARB_COOL;
        else if (!any_owner && !shared_req) st_d = ARB_COOL;
      end
      ARB_COOL:  st_d = ARB_IDLE;
      default:   st_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ARB_IDLE;
    else        st_q <= st_d;
  end

  assign chain_gnt = (st_q == ARB_GRANT);

  // R8: a sampled release pulls the grant down at the next edge
  assert_drop_on_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rel_any |=> !chain_gnt);
  // R8: the grant cannot come back in the cycle right after it was released
  assert_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chain_gnt) |=> !chain_gnt);
  // R10: the bus is never owned without the chain grant
  assert_owned_granted_R10: assert property (@(posedge clk) disable iff (!rst_n)
    any_owner |-> chain_gnt);
endmodule

// File: rtl/daisy_cell.sv
module daisy_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic gnt_in,
  input  logic req,
  input  logic rel,
  input  logic bus_busy,
  output logic gnt_out,
  output logic own,
  output logic rel_hit
);
  logic own_q;

  assign rel_hit = own_q & rel;
  assign gnt_out = gnt_in & ~req;
  assign own     = own_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                          own_q <= 1'b0;
    else if (rel_hit)                    own_q <= 1'b0;
    else if (gnt_in && req && !bus_busy) own_q <= 1'b1;
  end

  // R4: ownership is only taken with the grant present and a request
  assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(own_q) |-> $past(gnt_in && req));
  // R6: without its release the owner keeps the bus
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q && !rel) |=> own_q);
  // R7: a release at a non-owner leaves it without ownership unless it captures
  assert_stray_rel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!own_q && rel && !gnt_in) |=> !own_q);
endmodule

// File: rtl/daisy_arbiter.sv
module daisy_arbiter #(
  parameter int N_DEV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DEV-1:0] dev_req,
  input  logic [N_DEV-1:0] dev_rel,
  output logic [N_DEV-1:0] dev_own,
  output logic             shared_req,
  output logic             chain_gnt
);
  localparam int CHAIN_LEN = N_DEV + 1;

  logic [CHAIN_LEN-1:0] gnt_chain;
  logic [N_DEV-1:0]     own_vec;
  logic [N_DEV-1:0]     hit_vec;
  logic                 bus_busy;
  logic                 rel_any;

  assign shared_req = |dev_req;
  assign bus_busy   = |own_vec;
  assign rel_any    = |hit_vec;
  assign gnt_chain[0] = chain_gnt;

  daisy_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .shared_req (shared_req),
    .any_owner  (bus_busy),
    .rel_any    (rel_any),
    .chain_gnt  (chain_gnt)
  );

  for (genvar g = 0; g < N_DEV; g++) begin : g_cell
    daisy_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .gnt_in   (gnt_chain[g]),
      .req      (dev_req[g]),
      .rel      (dev_rel[g]),
      .bus_busy (bus_busy),
      .gnt_out  (gnt_chain[g+1]),
      .own      (own_vec[g]),
      .rel_hit  (hit_vec[g])
    );
  end

  assign dev_own = own_vec;

  // R5: ownership is exclusive
  assert_single_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(own_vec));
  // R9: a grant that finds no requester and no owner is withdrawn
  assert_withdraw_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_gnt && !shared_req && !bus_busy) |=> !chain_gnt);
endmodule

// File: tb/test_daisy_arbiter.sv
module test_daisy_arbiter;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] dev_req = '0;
  logic [N-1:0] dev_rel = '0;
  logic [N-1:0] dev_own;
  logic         shared_req;
  logic         chain_gnt;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  daisy_arbiter #(.N_DEV(N)) i_daisy_arbiter (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_rel(dev_rel),
    .dev_own(dev_own), .shared_req(shared_req), .chain_gnt(chain_gnt)
  );

  function automatic logic [N-1:0] low_bit(input logic [N-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  task automatic chk(input string req_tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(); step();
    chk("R1 own in reset", dev_own, 0);
    chk("R1 grant in reset", chain_gnt, 0);
    rst_n = 1'b1;
    step();
    chk("R1 own after reset", dev_own, 0);
    chk("R1 grant after reset", chain_gnt, 0);

    for (int p = 1; p < (1 << N); p++) begin
      logic [N-1:0] pat, win, win2, joined;
      pat = p[N-1:0];
      win = low_bit(pat);
      joined = pat | 1;
      win2 = low_bit(joined);
      dev_req = pat;
      #1 chk("R2 shared request", shared_req, 1);
      step();
      chk("R3 grant up", chain_gnt, 1);
      chk("R4 not yet owned", dev_own, 0);
      step();
      chk("R4 lowest requester owns", dev_own, win);
      chk("R5 single owner", $countones(dev_own), 1);
      // higher device joins, every non-owner pulses release
      dev_req = joined;
      dev_rel = ~win;
      step();
      dev_rel = '0;
      chk("R6 owner held", dev_own, win);
      chk("R7 stray release ignored", dev_own, win);
      chk("R10 grant while owned", chain_gnt, 1);
      dev_req = joined & ~win;
      step();
      chk("R6 held after own request drop", dev_own, win);
      if (joined & ~win) begin
        dev_rel = win;
        step();
        dev_rel = '0;
        chk("R8 own cleared", dev_own, 0);
        chk("R8 gap cycle 1", chain_gnt, 0);
        step();
        chk("R8 gap cycle 2", chain_gnt, 0);
        step();
        chk("R8 grant returns", chain_gnt, 1);
        step();
        chk("R4 re-arbitration", dev_own, low_bit(joined & ~win));
      end
      win = dev_own;
      dev_req = '0;
      dev_rel = win;
      step();
      dev_rel = '0;
      chk("R8 release to idle", dev_own, 0);
      step(); step();
      chk("R8 stays idle", chain_gnt, 0);
    end

    // vanishing request: grant rises, requests leave before capture
    dev_req = 4'b0100;
    step();
    chk("R3 grant for short request", chain_gnt, 1);
    dev_req = '0;
    #1 chk("R2 shared low", shared_req, 0);
    step();
    chk("R9 grant withdrawn", chain_gnt, 0);
    chk("R9 no owner", dev_own, 0);
    step(); step();
    chk("R9 still idle", chain_gnt, 0);

    // starvation: devices 0 and 3 keep asking, 0 always wins
    dev_req = 4'b1001;
    for (int k = 0; k < 5; k++) begin
      step(); step();
      chk("R4 starvation winner", dev_own, 4'b0001);
      dev_rel = 4'b0001;
      step();
      dev_rel = '0;
      step();
    end
    dev_req = '0;
    step(); step(); step();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule